// File: doc/BRIEF.md
# Configurable Interrupt Line Controller

This block gathers 32 asynchronous interrupt request lines and presents them to a processor as two request outputs, a normal one and a fast one. Every line is handled on its own terms: software picks whether it is sensed as a level or as an edge, and whether high/rising or low/falling counts as active. Edge events are held in a per-line status bit until software writes a 1 to that bit. Level lines simply track their input.

A 32-bit register port with word-aligned byte addresses gives software access to the enable mask, the raw status, the enabled status, the polarity, the trigger kind and the output routing. Software reads the enabled status and services the set bits starting from bit 0. Because the outputs are plain level requests, one controller's `irq_o` can be wired to an input line of another controller to form a cascade.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the enable (offset 0x00), polarity (0x0C), trigger (0x10) and routing (0x14) registers read 0, the enabled status reads 0, and both `irq_o` and `fiq_o` are low.
- R2: The enable, polarity, trigger and routing registers read back what was written at their offsets; a write to the enabled-status offset 0x08 changes nothing.
- R3: For a line whose trigger bit is 0 (level), the raw status bit at 0x04 equals the input when its polarity bit is 1 and the inverted input when it is 0; a change on the pin reaches the raw bit three clock edges after it is sampled (two synchroniser stages plus the status register).
- R4: For a line whose trigger bit is 1 (edge), a 0-to-1 transition sets the raw bit when polarity is 1 and a 1-to-0 transition sets it when polarity is 0; the bit stays set after the input returns.
- R5: Writing a 1 to a raw status bit of an edge line clears it; bits written with 0 keep their value.
- R6: Writing a 1 to the raw bit of a level line whose input is still active leaves the bit reading 1.
- R7: The enabled status at 0x08 reads as raw status AND enable mask.
- R8: `irq_o` is the OR of enabled status bits whose routing bit is 0; `fiq_o` is the OR of enabled status bits whose routing bit is 1.
- R9: When an edge event on a line and a write-1 clear of that line's raw bit take effect at the same clock edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_line_i | input | 32 | Asynchronous interrupt request lines |
| bus_addr_i | input | 5 | Byte address of the register access |
| bus_wen_i | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The two functions that can meet in one cycle are the arrival of a synchronised edge on a line and a software write-1 clear of that same line's raw bit. The bench raises the pin on a falling clock edge, counts the two synchroniser stages, and places the clear write so its strobe is sampled on exactly the edge where the status register also sees the new event. It then reads the raw status and the request outputs: the bit must be set and the request asserted, while an identical clear one cycle away from any event must leave the bit at 0.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Word index of each register (byte offset divided by four)
    typedef enum logic [2:0] {
        RI_ENABLE   = 3'd0,
        RI_RAW      = 3'd1,
        RI_STATUS   = 3'd2,
        RI_POLARITY = 3'd3,
        RI_TRIGGER  = 3'd4,
        RI_ROUTE    = 3'd5
    } reg_idx_e;

    localparam int unsigned REG_IDX_W = 3;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_i;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stage2;

endmodule

// File: rtl/irqc_trigger.sv
module irqc_trigger #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] act_o,
    output logic [W-1:0] evt_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } trig_t;

    trig_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        logic rise, fall;
        assign rise     = sync_i[i] & ~st_q.prev[i];
        assign fall     = ~sync_i[i] & st_q.prev[i];
        assign evt_o[i] = pol_i[i] ? rise : fall;
        assign act_o[i] = pol_i[i] ? sync_i[i] : ~sync_i[i];
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wen_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o,
    input  logic [W-1:0]  act_i,
    input  logic [W-1:0]  evt_i,
    output logic [W-1:0]  enable_o,
    output logic [W-1:0]  pol_o,
    output logic [W-1:0]  route_o,
    output logic [W-1:0]  status_o
);

    localparam int unsigned IDX_W = AW - 2;

    typedef struct packed {
        logic [W-1:0] enable;
        logic [W-1:0] pol;
        logic [W-1:0] trig;
        logic [W-1:0] route;
        logic [W-1:0] raw;
    } regs_t;

    regs_t st_d, st_q;

    logic [IDX_W-1:0] word;
    logic             aligned;
    logic [W-1:0]     clr;
    logic [W-1:0]     status;

    assign word    = addr_i[AW-1:2];
    assign aligned = (addr_i[1:0] == 2'b00);
    assign status  = st_q.raw & st_q.enable;

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (wen_i && aligned) begin
            case (word)
                IDX_W'(RI_ENABLE):   st_d.enable = wdata_i;
                IDX_W'(RI_RAW):      clr         = wdata_i;
                IDX_W'(RI_POLARITY): st_d.pol    = wdata_i;
                IDX_W'(RI_TRIGGER):  st_d.trig   = wdata_i;
                IDX_W'(RI_ROUTE):    st_d.route  = wdata_i;
                default: ;
            endcase
        end
        // edge lines latch and clear on write-1 (new event wins); level lines follow
        st_d.raw = (st_q.trig & ((st_q.raw & ~clr) | evt_i)) | (~st_q.trig & act_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            case (word)
                IDX_W'(RI_ENABLE):   rdata_o = st_q.enable;
                IDX_W'(RI_RAW):      rdata_o = st_q.raw;
                IDX_W'(RI_STATUS):   rdata_o = status;
                IDX_W'(RI_POLARITY): rdata_o = st_q.pol;
                IDX_W'(RI_TRIGGER):  rdata_o = st_q.trig;
                IDX_W'(RI_ROUTE):    rdata_o = st_q.route;
                default:             rdata_o = '0;
            endcase
        end
    end

    assign enable_o = st_q.enable;
    assign pol_o    = st_q.pol;
    assign route_o  = st_q.route;
    assign status_o = status;

    // a write-1 clear without a concurrent event empties an edge line
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.raw & $past(st_q.trig & clr & ~evt_i)) == '0));

    // an event on an edge line always leaves its bit set, even against a clear
    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.trig & evt_i) & ~st_q.raw) == '0));

    // level lines mirror the adjusted input one edge later
    assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(act_i) ^ st_q.raw) & ~$past(st_q.trig)) == '0));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
    parameter int unsigned NLINES = 32,
    parameter int unsigned AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_line_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic              bus_wen_i,
    input  logic [NLINES-1:0] bus_wdata_i,
    output logic [NLINES-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);

    logic [NLINES-1:0] sync_lines;
    logic [NLINES-1:0] act, evt;
    logic [NLINES-1:0] enable, pol, route, status;

    irqc_sync #(.W(NLINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_line_i),
        .sync_o  (sync_lines)
    );

    irqc_trigger #(.W(NLINES)) u_trigger (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_lines),
        .pol_i  (pol),
        .act_o  (act),
        .evt_o  (evt)
    );

    irqc_regs #(.W(NLINES), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr_i),
        .wen_i    (bus_wen_i),
        .wdata_i  (bus_wdata_i),
        .rdata_o  (bus_rdata_o),
        .act_i    (act),
        .evt_i    (evt),
        .enable_o (enable),
        .pol_o    (pol),
        .route_o  (route),
        .status_o (status)
    );

    assign irq_o = |(status & ~route);
    assign fiq_o = |(status & route);

    // nothing is reported for a line that is disabled
    assert_status_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~enable) == '0));

    // no enabled pending line means no request on either output
    assert_quiet_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> (!irq_o && !fiq_o));

endmodule

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;

    localparam logic [4:0] OFF_EN    = 5'h00;
    localparam logic [4:0] OFF_RAW   = 5'h04;
    localparam logic [4:0] OFF_ST    = 5'h08;
    localparam logic [4:0] OFF_POL   = 5'h0C;
    localparam logic [4:0] OFF_TRIG  = 5'h10;
    localparam logic [4:0] OFF_ROUTE = 5'h14;

    typedef struct packed {
        logic [31:0] en;
        logic [31:0] pol;
        logic [31:0] route;
        logic [31:0] lines;
        logic [31:0] raw;
        logic [31:0] stat;
        logic        irq;
        logic        fiq;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VT [NVEC] = '{
        '{en:32'h0000_00FF, pol:32'hFFFF_FFFF, route:32'h0000_000F, lines:32'h0000_00F0,
          raw:32'h0000_00F0, stat:32'h0000_00F0, irq:1'b1, fiq:1'b0},
        '{en:32'h0000_0030, pol:32'h0000_0000, route:32'h0000_0010, lines:32'hFFFF_FF0F,
          raw:32'h0000_00F0, stat:32'h0000_0030, irq:1'b1, fiq:1'b1},
        '{en:32'h0000_0000, pol:32'h0000_FFFF, route:32'hFFFF_FFFF, lines:32'h1234_5678,
          raw:32'hEDCB_5678, stat:32'h0000_0000, irq:1'b0, fiq:1'b0},
        '{en:32'h8000_0000, pol:32'hFFFF_0000, route:32'h8000_0000, lines:32'h8000_0001,
          raw:32'h8000_FFFE, stat:32'h8000_0000, irq:1'b0, fiq:1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line = '0;
    logic [4:0]  addr = '0;
    logic        wen = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_line_i  (line),
        .bus_addr_i  (addr),
        .bus_wen_i   (wen),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .fiq_o       (fiq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #0.1;
        d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 reset state
        rd(OFF_EN, v);    chk("R1 enable", v, 32'h0);
        rd(OFF_POL, v);   chk("R1 polarity", v, 32'h0);
        rd(OFF_TRIG, v);  chk("R1 trigger", v, 32'h0);
        rd(OFF_ROUTE, v); chk("R1 route", v, 32'h0);
        rd(OFF_ST, v);    chk("R1 status", v, 32'h0);
        chk("R1 irq/fiq", {30'h0, irq, fiq}, 32'h0);
        // R3: all lines low, active-low level -> all raw bits set
        rd(OFF_RAW, v);   chk("R3 reset raw active-low", v, 32'hFFFF_FFFF);

        // table of level-mode vectors: R3, R7, R8
        for (int i = 0; i < NVEC; i++) begin
            wr(OFF_TRIG, 32'h0);
            wr(OFF_POL, VT[i].pol);
            wr(OFF_EN, VT[i].en);
            wr(OFF_ROUTE, VT[i].route);
            line = VT[i].lines;
            settle();
            rd(OFF_RAW, v); chk("R3 table raw", v, VT[i].raw);
            rd(OFF_ST, v);  chk("R7 table status", v, VT[i].stat);
            chk("R8 table irq/fiq", {30'h0, irq, fiq}, {30'h0, VT[i].irq, VT[i].fiq});
        end

        // R2 readback and read-only status
        wr(OFF_EN, 32'h0);
        wr(OFF_POL, 32'hA5A5_5A5A);   rd(OFF_POL, v);   chk("R2 polarity", v, 32'hA5A5_5A5A);
        wr(OFF_TRIG, 32'h0F0F_F0F0);  rd(OFF_TRIG, v);  chk("R2 trigger", v, 32'h0F0F_F0F0);
        wr(OFF_ROUTE, 32'h3C3C_C3C3); rd(OFF_ROUTE, v); chk("R2 route", v, 32'h3C3C_C3C3);
        wr(OFF_EN, 32'h0000_0000);
        wr(OFF_ST, 32'hFFFF_FFFF);    rd(OFF_ST, v);    chk("R2 status write ignored", v, 32'h0);
        rd(OFF_EN, v);                chk("R2 enable after status write", v, 32'h0);
        wr(OFF_EN, 32'h1234_ABCD);    rd(OFF_EN, v);    chk("R2 enable", v, 32'h1234_ABCD);

        // R3 latency: level active-high, line0
        wr(OFF_EN, 32'h0);
        wr(OFF_TRIG, 32'h0);
        wr(OFF_POL, 32'hFFFF_FFFF);
        line = 32'h0;
        settle();
        line = 32'h1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(OFF_RAW, v); chk("R3 not yet after two edges", v, 32'h0);
        @(posedge clk);
        @(negedge clk);
        rd(OFF_RAW, v); chk("R3 set after three edges", v, 32'h1);

        // R4 edge capture: line0 rising, line1 falling
        wr(OFF_TRIG, 32'hFFFF_FFFF);
        wr(OFF_POL, 32'h0000_0001);
        line = 32'h2;
        settle();
        wr(OFF_RAW, 32'hFFFF_FFFF);
        rd(OFF_RAW, v); chk("R5 clear all edge bits", v, 32'h0);
        line = 32'h3;
        settle();
        rd(OFF_RAW, v); chk("R4 rising edge line0", v, 32'h1);
        line = 32'h2;
        settle();
        rd(OFF_RAW, v); chk("R4 held after input returns", v, 32'h1);
        line = 32'h0;
        settle();
        rd(OFF_RAW, v); chk("R4 falling edge line1", v, 32'h3);

        // R5 selective write-1 clear
        wr(OFF_RAW, 32'h1); rd(OFF_RAW, v); chk("R5 clear bit0 only", v, 32'h2);
        wr(OFF_RAW, 32'h0); rd(OFF_RAW, v); chk("R5 zero write no effect", v, 32'h2);
        wr(OFF_RAW, 32'h2); rd(OFF_RAW, v); chk("R5 clear bit1", v, 32'h0);

        // R6 clear on an active level line
        wr(OFF_TRIG, 32'hFFFF_FFFB);
        wr(OFF_POL, 32'h0000_0005);
        line = 32'h4;
        settle();
        rd(OFF_RAW, v); chk("R6 level line active", v, 32'h4);
        wr(OFF_RAW, 32'h4);
        rd(OFF_RAW, v); chk("R6 clear has no lasting effect", v, 32'h4);
        line = 32'h0;
        settle();
        rd(OFF_RAW, v); chk("R3 level line released", v, 32'h0);

        // R9 edge and clear on the same edge
        wr(OFF_TRIG, 32'hFFFF_FFFF);
        wr(OFF_POL, 32'h0000_0001);
        wr(OFF_EN, 32'h0000_0001);
        wr(OFF_ROUTE, 32'h0);
        settle();
        wr(OFF_RAW, 32'hFFFF_FFFF);
        rd(OFF_RAW, v); chk("R5 cleared before collision", v, 32'h0);
        line = 32'h1;             // sampled at edge k, event seen at edge k+2
        @(negedge clk);
        wr(OFF_RAW, 32'h1);       // write strobe sampled at edge k+2
        rd(OFF_RAW, v); chk("R9 event beats clear", v, 32'h1);
        chk("R8 routed to irq", {30'h0, irq, fiq}, 32'h2);
        wr(OFF_ROUTE, 32'h1);
        chk("R8 routed to fiq", {30'h0, irq, fiq}, 32'h1);
        wr(OFF_RAW, 32'h1);
        rd(OFF_RAW, v); chk("R5 clear without event", v, 32'h0);
        chk("R8 outputs idle", {30'h0, irq, fiq}, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule